// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM with four 9-bit byte lanes and a flow-through read path. Address, chip enables, burst strobes, write controls and write data are all captured on the rising clock edge. Read data for the address captured at an edge appears on the output later in that same clock cycle. No output register sits in the read path. A two-bit burst sequencer inside the block produces up to four consecutive addresses from one loaded start address. It counts either in linear order or in interleaved order.

Two start strobes begin an access. The processor strobe always starts a read, and it only takes effect when the primary enable is low. The controller strobe starts a read or a write according to the write controls. Between strobes the advance input either steps the burst address or holds it, and each cycle still reads or writes according to the write controls.

The bidirectional data bus is split into three signals: a write-data input, a read-data output, and an output-valid flag that stands for the driver enable. An asynchronous output enable can turn the drivers off. A clocked sleep input halts all access and keeps the memory contents.

Top module: `fts_burst_sram`

## Requirements
- R1: With `gwe_ni` low, a write cycle stores all four lanes of `wdata_i`, whatever the values of `bwe_ni` and `lane_we_ni`.
- R2: With `gwe_ni` high and `bwe_ni` low, the cycle writes only the lanes i whose `lane_we_ni[i]` is low, in any combination. Lane i occupies bits [9i+8:9i]. If `bwe_ni` is high, or if no lane bit is low, the cycle is a read.
- R3: An access is selected only when `en_pri_ni`=0, `en_sec_i`=1 and `en_ter_ni`=0 on the strobe cycle. A strobe seen with any other enable combination deselects the block, and the output stays off until the next selecting strobe. `en_sec_i` and `en_ter_ni` are ignored on cycles without a strobe.
- R4: `start_cpu_ni` low together with `en_pri_ni` low starts a burst at `addr_i`. It has priority over the controller strobe and is always a read. `start_ctl_ni` low starts a burst at `addr_i` that is a read or a write according to R1 and R2. When `en_pri_ni` is high, `start_cpu_ni` is ignored.
- R5: On a cycle with no effective strobe during an active burst, `adv_ni` low steps to the next burst address and `adv_ni` high holds the current one. The write controls pick read or write on each such cycle.
- R6: The burst address keeps the upper bits of the start address. For step n (0..3) its two low bits are start+n mod 4 when `lin_order_ni`=0, and start XOR n when `lin_order_ni`=1. The fifth address wraps back to the start.
- R7: For a read whose address is captured at edge k, `rdata_oe_o` is 1 and `rdata_o` holds all 36 bits of that word between edge k and edge k+1. The lane write enables have no effect on which lanes are driven.
- R8: `rdata_oe_o` is 0 after reset, after every write cycle and after every deselect cycle.
- R9: `oe_ni` high forces `rdata_oe_o` to 0 at once, without waiting for a clock edge. `oe_ni` low turns the output on only during an active read. A read with `oe_ni` high still advances the burst address.
- R10: While `sleep_i` is sampled high, all accesses are ignored, `rdata_oe_o` is 0, the burst is ended and the memory contents are kept. The first two edges after `sleep_i` is sampled low also ignore strobes, and the third edge honours them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, loaded on a strobe |
| en_pri_ni | input | 1 | Primary enable, active low; also gates the processor strobe |
| en_sec_i | input | 1 | Secondary enable, active high, sampled on strobe cycles |
| en_ter_ni | input | 1 | Tertiary enable, active low, sampled on strobe cycles |
| start_cpu_ni | input | 1 | Processor start strobe, active low, read only |
| start_ctl_ni | input | 1 | Controller start strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwe_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write qualifier, active low |
| lane_we_ni | input | LANES | Per-lane write selects, active low |
| lin_order_ni | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high, sampled on the clock |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_oe_o | output | 1 | Read data driven (driver enable) |

## Verification
Strobe, advance, write and sleep decisions take effect at the edge that samples them. Read data for that edge is due on `rdata_o` in the same cycle, so no extra delay follows the edge. The bench changes inputs on the falling edge and steps its reference model on the rising edge. It then compares `rdata_oe_o` and `rdata_o` at the next falling edge, which falls inside the cycle the read belongs to. Writes are checked by later reads through the normal port. The output enable has no clock, so the bench toggles `oe_ni` in mid-cycle and samples the output one time unit later.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int BURST_W = 2;

  // low address bits for burst step 'step' from 'start'
  function automatic logic [BURST_W-1:0] burst_lo(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] step,
                                                  input logic               linear);
    return linear ? start + step : start ^ step;
  endfunction
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_pri_ni,
  input  logic              en_sec_i,
  input  logic              en_ter_ni,
  input  logic              start_cpu_ni,
  input  logic              start_ctl_ni,
  input  logic              adv_ni,
  input  logic              gwe_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic              lin_order_ni,
  input  logic              sleep_i,
  output logic [LANES-1:0]  wr_mask_o,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_act_o
);
  import fts_pkg::*;
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  logic              act_q, rd_q;
  logic [ADDR_W-1:0] base_q, rd_addr_q;
  logic [BURST_W-1:0] off_q;
  logic [WAKE_W-1:0] wake_q;

  logic              awake, start_cpu, start_ctl, start, selected, is_wr;
  logic              act_d, rd_d;
  logic [LANES-1:0]  lane_sel;
  logic [ADDR_W-1:0] base_d;
  logic [BURST_W-1:0] off_d;

  always_comb begin
    lane_sel  = !gwe_ni ? '1 : (!bwe_ni ? ~lane_we_ni : '0);
    awake     = !sleep_i && (wake_q == '0);
    start_cpu = !start_cpu_ni && !en_pri_ni;
    start_ctl = !start_cpu && !start_ctl_ni;
    start     = start_cpu || start_ctl;
    selected  = !en_pri_ni && en_sec_i && !en_ter_ni;
    act_d     = awake && (start ? selected : act_q);
    base_d    = (awake && start) ? addr_i : base_q;
    if (awake && start)                off_d = '0;
    else if (awake && act_q && !adv_ni) off_d = off_q + BURST_W'(1);
    else                               off_d = off_q;
    // cpu-started bursts are reads in their first cycle
    is_wr     = (|lane_sel) && !start_cpu;
    acc_addr_o = {base_d[ADDR_W-1:BURST_W],
                  burst_lo(base_d[BURST_W-1:0], off_d, !lin_order_ni)};
    wr_mask_o = (act_d && is_wr) ? lane_sel : '0;
    rd_d      = act_d && !is_wr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      rd_q      <= 1'b0;
      base_q    <= '0;
      off_q     <= '0;
      rd_addr_q <= '0;
      wake_q    <= '0;
    end else begin
      act_q     <= act_d;
      rd_q      <= rd_d;
      base_q    <= base_d;
      off_q     <= off_d;
      rd_addr_q <= acc_addr_o;
      if (sleep_i)            wake_q <= WAKE_W'(WAKE_CYC);
      else if (wake_q != '0)  wake_q <= wake_q - WAKE_W'(1);
    end
  end

  assign rd_addr_o = rd_addr_q;
  assign rd_act_o  = rd_q;
endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic [LANES-1:0]        wr_mask_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_mask_i[g]) mem[wr_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
    end
    assign rd_data_o[g*LANE_W +: LANE_W] = mem[rd_addr_i];
  end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    en_pri_ni,
  input  logic                    en_sec_i,
  input  logic                    en_ter_ni,
  input  logic                    start_cpu_ni,
  input  logic                    start_ctl_ni,
  input  logic                    adv_ni,
  input  logic                    gwe_ni,
  input  logic                    bwe_ni,
  input  logic [LANES-1:0]        lane_we_ni,
  input  logic                    lin_order_ni,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] acc_addr, rd_addr;
  logic              rd_act;
  logic [DATA_W-1:0] rd_data;

  fts_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_seq (
    .clk_i, .rst_ni, .addr_i, .en_pri_ni, .en_sec_i, .en_ter_ni,
    .start_cpu_ni, .start_ctl_ni, .adv_ni, .gwe_ni, .bwe_ni, .lane_we_ni,
    .lin_order_ni, .sleep_i,
    .wr_mask_o(wr_mask), .acc_addr_o(acc_addr), .rd_addr_o(rd_addr), .rd_act_o(rd_act)
  );

  fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i, .wr_mask_i(wr_mask), .wr_addr_i(acc_addr), .wr_data_i(wdata_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // flow-through: array read straight from the registered address
  assign rdata_oe_o = rd_act && !oe_ni;
  assign rdata_o    = rdata_oe_o ? rd_data : '0;
endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_sec_i,
  input logic start_ctl_ni,
  input logic start_cpu_ni,
  input logic gwe_ni,
  input logic oe_ni,
  input logic sleep_i,
  input logic rdata_oe_o
);
  // R9: output enable high blocks the drivers
  p_oe_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rdata_oe_o);

  // R10: sleep sampled high leaves the output off for the next cycle
  p_sleep_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !rdata_oe_o);

  // R10: first edge after sleep release still ignores access
  p_wake_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |=> !rdata_oe_o);

  // R8: a global write without a processor strobe never drives
  p_write_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gwe_ni && start_cpu_ni) |=> !rdata_oe_o);

  // R3: any strobe with the secondary enable low deselects
  p_desel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_ctl_ni && !en_sec_i) |=> !rdata_oe_o);
endmodule

bind fts_burst_sram fts_burst_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_sec_i(en_sec_i), .start_ctl_ni(start_ctl_ni),
  .start_cpu_ni(start_cpu_ni), .gwe_ni(gwe_ni), .oe_ni(oe_ni), .sleep_i(sleep_i),
  .rdata_oe_o(rdata_oe_o)
);

// File: tb/fts_burst_sram_tb.sv
module fts_burst_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic e1_n = 1'b0, e2 = 1'b1, e3_n = 1'b0;
  logic cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic gwe_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, sleep = 1'b0, lin_n = 1'b0;
  logic [NL-1:0] lane_n = '1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  fts_burst_sram u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .en_pri_ni(e1_n), .en_sec_i(e2),
    .en_ter_ni(e3_n), .start_cpu_ni(cpu_n), .start_ctl_ni(ctl_n), .adv_ni(adv_n),
    .gwe_ni(gwe_n), .bwe_ni(bwe_n), .lane_we_ni(lane_n), .lin_order_ni(lin_n),
    .oe_ni(oe_n), .sleep_i(sleep), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] ref_mem [1<<AW];
  logic [AW-1:0] m_base = '0, m_addr = '0;
  int m_off = 0, m_wake = 0;
  bit m_act = 0, m_rd = 0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 32'h0137_2A59) ^ DW'(36'h5A5A5A5A5) ^ (DW'(a) << 30);
  endfunction

  task automatic model_edge();
    logic [NL-1:0] mask;
    logic [1:0] lo;
    bit wr, sp, sc;
    mask = !gwe_n ? '1 : (!bwe_n ? ~lane_n : '0);
    if (sleep) begin m_act = 0; m_rd = 0; m_wake = 2; return; end
    if (m_wake > 0) begin m_wake--; m_act = 0; m_rd = 0; return; end
    sp = !cpu_n && !e1_n;
    sc = !sp && !ctl_n;
    wr = (mask != 0);
    if (sp || sc) begin
      m_act = !e1_n && e2 && !e3_n;
      m_base = addr;
      m_off = 0;
      if (sp) wr = 0;
    end else if (m_act && !adv_n) m_off = (m_off + 1) % 4;
    m_rd = 0;
    if (m_act) begin
      lo = lin_n ? (m_base[1:0] ^ 2'(m_off)) : 2'(m_base[1:0] + 2'(m_off));
      m_addr = {m_base[AW-1:2], lo};
      if (wr) begin
        for (int i = 0; i < NL; i++)
          if (mask[i]) ref_mem[m_addr][i*LW +: LW] = wdata[i*LW +: LW];
      end else m_rd = 1;
    end
  endtask

  task automatic check(input string tag, input bit got_oe, input logic [DW-1:0] got_d,
                       input bit exp_oe, input logic [DW-1:0] exp_d);
    checks++;
    if (got_oe !== exp_oe || (exp_oe && got_d !== exp_d)) begin
      errors++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag, got_oe, got_d, exp_oe, exp_d);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, rdata_oe, rdata, m_rd && !oe_n, m_rd ? ref_mem[m_addr] : '0);
  endtask

  task automatic ctl(input logic [AW-1:0] a, input bit g, input bit b, input logic [NL-1:0] l,
                     input logic [DW-1:0] d);
    addr = a; ctl_n = 0; cpu_n = 1; adv_n = 1; gwe_n = g; bwe_n = b; lane_n = l; wdata = d;
  endtask

  task automatic cpu(input logic [AW-1:0] a, input bit g);
    addr = a; cpu_n = 0; ctl_n = 1; adv_n = 1; gwe_n = g; bwe_n = 1; lane_n = '1; wdata = '1;
  endtask

  task automatic cont(input bit adv, input bit g, input logic [DW-1:0] d);
    cpu_n = 1; ctl_n = 1; adv_n = adv; gwe_n = g; bwe_n = 1; lane_n = '1; wdata = d;
    addr = ~addr;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    ctl(a, 1, 1, '1, '0);
    tick(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", rdata_oe, rdata, 1'b0, '0);           // reset state
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fill through global write, byte controls set to "no lanes"
    for (int a = 0; a < (1 << AW); a++) begin
      ctl(AW'(a), 0, 0, '1, pat(a));
      tick("R1");
    end
    rd(AW'(3), "R1");
    rd(AW'(40), "R7");

    // R2: byte writes
    ctl(AW'(5), 1, 0, 4'b1010, {4{9'h1C3}});
    tick("R2");
    rd(AW'(5), "R2");
    ctl(AW'(7), 1, 0, 4'b0110, {4{9'h0A5}});
    tick("R2");
    rd(AW'(7), "R2");
    ctl(AW'(8), 1, 0, 4'b1111, {4{9'h1FF}});   // no lanes: a read
    tick("R2");
    ctl(AW'(8), 1, 1, 4'b0000, {4{9'h111}});   // bwe high: a read, lanes driven
    tick("R7");

    // R4: cpu strobe is a read despite global write low
    cpu(AW'(10), 0);
    wdata = '0;
    tick("R4");
    rd(AW'(10), "R4");
    // cpu strobe has priority over ctl strobe
    cpu(AW'(11), 1);
    ctl_n = 0; gwe_n = 0; wdata = '0;
    tick("R4");
    rd(AW'(11), "R4");

    // R6 / R5: linear burst from 6
    lin_n = 0;
    ctl(AW'(6), 1, 1, '1, '0); tick("R6");
    for (int i = 0; i < 4; i++) begin cont(0, 1, '0); tick("R6"); end
    cont(1, 1, '0); tick("R5");                      // suspend holds
    cont(1, 1, '0); tick("R5");
    // interleaved burst from 9
    lin_n = 1;
    ctl(AW'(9), 1, 1, '1, '0); tick("R6");
    for (int i = 0; i < 4; i++) begin cont(0, 1, '0); tick("R6"); end
    lin_n = 0;

    // R5: burst write, then read back
    ctl(AW'(14), 0, 1, '1, {4{9'h033}}); tick("R5");
    cont(0, 0, {4{9'h144}}); tick("R5");
    cont(1, 0, {4{9'h155}}); tick("R5");               // suspend write overwrites 15
    cont(0, 0, {4{9'h066}}); tick("R5");
    cont(0, 1, '0); tick("R5");                         // read continues at 13
    rd(AW'(14), "R5");
    rd(AW'(15), "R5");
    rd(AW'(12), "R5");

    // R3: enable rule
    ctl(AW'(20), 1, 1, '1, '0); e2 = 0; tick("R3");
    e2 = 1;
    cont(0, 1, '0); tick("R3");                          // stays deselected
    cpu(AW'(21), 1); e3_n = 1; tick("R3");
    e3_n = 0;
    rd(AW'(22), "R3");
    cont(0, 1, '0); e2 = 0; e3_n = 1; tick("R3");       // ignored off-strobe
    e2 = 1; e3_n = 0;
    // R4: cpu strobe with primary enable high is ignored, ctl high -> continue
    cpu(AW'(30), 1); e1_n = 1; adv_n = 0; tick("R4");
    ctl(AW'(31), 1, 1, '1, '0); e1_n = 1; tick("R3");    // ctl strobe with e1 high: deselect
    e1_n = 0;

    // R9: dummy read advances, async oe
    ctl(AW'(32), 1, 1, '1, '0); oe_n = 1; tick("R9");
    oe_n = 0;
    cont(0, 1, '0); tick("R9");                          // expects address 33
    oe_n = 1; #1;
    check("R9", rdata_oe, rdata, 1'b0, '0);
    oe_n = 0; #1;
    check("R9", rdata_oe, rdata, 1'b1, ref_mem[33]);

    // R8: write cycles keep output off
    rd(AW'(34), "R7");
    ctl(AW'(34), 0, 1, '1, {4{9'h0F0}}); tick("R8");

    // R10: sleep
    rd(AW'(40), "R10");
    sleep = 1;
    ctl(AW'(20), 0, 1, '1, '0); tick("R10");
    cont(0, 0, '1); tick("R10");
    sleep = 0;
    rd(AW'(3), "R10");                                   // ignored
    rd(AW'(3), "R10");                                   // ignored
    rd(AW'(3), "R10");                                   // honoured
    rd(AW'(20), "R10");                                  // contents kept
    rd(AW'(40), "R10");
    sleep = 1;
    rd(AW'(41), "R10");
    sleep = 0;
    cont(0, 1, '0); tick("R10");
    cont(0, 1, '0); tick("R10");
    cont(0, 1, '0); tick("R10");                          // burst ended by sleep

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule